// File: doc/BRIEF.md
# Power-Gating Slot Sequencer

This block switches a group of gated power domains on and off in a fixed order of time slots, so that the inrush current of a power-up, or the disturbance of a power-down, is spread over time instead of landing in one cycle. Each of the slots holds two domain masks: the domains to switch on and the domains to switch off. A sequence begins on a software start bit or on a hardware sleep or wake event. The same slot program serves first power-on and the return from a deep-sleep mode.

Once started, the sequencer walks the slots from index 0 upward. For each slot it raises a request level for every affected domain and waits until each of those domains acknowledges. It then runs a programmable number of idle settle cycles before it fetches the next slot. If acknowledges do not arrive within a programmable limit, the sequence is abandoned and a sticky error flag is raised. At the end, a one-cycle done pulse marks completion, and a vector shows which domains are now powered.

The slot table sits in a small synchronous-read memory with one write port. Settle length and timeout limit are plain inputs held by the surrounding control logic.

Top module: `pgate_slot_seq`

## Requirements
- R1: After reset, busy, done, err, every request and every bit of dom_on are 0.
- R2: While busy is 0, a high level on sw_start or hw_evt at a clock edge starts a sequence. busy is 1 from the next cycle, and err is cleared to 0 at that same edge.
- R3: While busy is 1, sw_start and hw_evt have no effect. After done, busy stays 0 and no further requests or done pulses appear until a new trigger arrives.
- R4: Slots are visited strictly in ascending index from 0 to NUM_SLOT-1. A slot is written through cfg_we/cfg_slot/cfg_up/cfg_dn, with bit i of each mask meaning domain i. A slot's requests rise together, stay constant until every requested domain has its matching acknowledge high, and then fall together. No later slot's request appears before that.
- R5: When a domain is set in both masks of a slot, only the power-up request is issued. up_req and dn_req are never high for the same domain.
- R6: A slot whose two masks are both zero issues no request and costs exactly two cycles. With every slot empty, busy is high for exactly 2*NUM_SLOT cycles.
- R7: Between the falling requests of one non-empty slot and the rising requests of the next non-empty slot there are exactly settle_cycles + 2 cycles with no request, plus 2 cycles for each empty slot between them.
- R8: When a slot completes, dom_on becomes (dom_on | up_req) & ~dn_req. dom_on does not change while busy is 0.
- R9: After the last slot completes, done is high for exactly one cycle, the same cycle in which busy first reads 0, and exactly one done occurs per completed sequence.
- R10: If a slot still has a missing acknowledge after its requests have been high for tmo_limit+1 cycles, all requests fall, err goes to 1, busy goes to 0, and no done is given. dom_on keeps its value from before that slot. err stays 1 while idle.
- R11: A new sequence started after an error clears err and runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_slot | input | SLOT_W (5) | Slot index to write |
| cfg_up | input | NUM_DOM (8) | Power-up mask for the written slot |
| cfg_dn | input | NUM_DOM (8) | Power-down mask for the written slot |
| settle_cycles | input | SETTLE_W (8) | Idle cycles after each completed slot |
| tmo_limit | input | TMO_W (12) | Acknowledge wait limit per slot |
| sw_start | input | 1 | Software start level |
| hw_evt | input | 1 | Hardware sleep/wake start level |
| up_req | output | NUM_DOM (8) | Power-up request level per domain |
| dn_req | output | NUM_DOM (8) | Power-down request level per domain |
| up_ack | input | NUM_DOM (8) | Power-up acknowledge per domain |
| dn_ack | input | NUM_DOM (8) | Power-down acknowledge per domain |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | Sticky timeout flag |
| dom_on | output | NUM_DOM (8) | Domains currently powered |

## Verification
The bench watches every request edge against a slot program it computed itself. A design that skipped a slot, reordered slots, or overlapped two slots would show a mask mismatch. A design that miscounted settle or empty-slot cycles would show an idle gap of the wrong length. Domains with different acknowledge delays test whether completion waits for the slowest domain. A design that advanced on the first acknowledge would drop requests early and break the gap and stability checks. A conflicting up/down pair in a slot shows whether power-up takes priority. A domain that never acknowledges tests the timeout length, that no done pulse follows the abort, and that dom_on is left untouched; a following sequence shows whether err clears. Start pulses injected mid-sequence expose a design that restarts or emits a second done.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EVAL,
    ST_WAIT,
    ST_SETTLE
  } seq_state_t;
endpackage

// File: rtl/pgs_slot_ram.sv
module pgs_slot_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 20,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // synchronous read so the table maps onto block RAM
  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgs_dom_hs.sv
module pgs_dom_hs (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clear,
  input  logic up_set,
  input  logic dn_set,
  input  logic up_ack,
  input  logic dn_ack,
  output logic up_req,
  output logic dn_req,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      up_req <= 1'b0;
      dn_req <= 1'b0;
    end else if (load) begin
      up_req <= up_set;
      dn_req <= dn_set & ~up_set;   // power-up wins a conflict
    end
  end

  assign pending = (up_req & ~up_ack) | (dn_req & ~dn_ack);
endmodule

// File: rtl/pgs_limit_cnt.sv
module pgs_limit_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt_q <= '0;
    else if (inc && !hit) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == limit);
endmodule

// File: rtl/pgate_slot_seq.sv
module pgate_slot_seq
  import pgs_pkg::*;
#(
  parameter int NUM_DOM  = 8,
  parameter int NUM_SLOT = 20,
  parameter int SETTLE_W = 8,
  parameter int TMO_W    = 12,
  localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [SLOT_W-1:0]   cfg_slot,
  input  logic [NUM_DOM-1:0]  cfg_up,
  input  logic [NUM_DOM-1:0]  cfg_dn,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [TMO_W-1:0]    tmo_limit,
  input  logic                sw_start,
  input  logic                hw_evt,
  output logic [NUM_DOM-1:0]  up_req,
  output logic [NUM_DOM-1:0]  dn_req,
  input  logic [NUM_DOM-1:0]  up_ack,
  input  logic [NUM_DOM-1:0]  dn_ack,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [NUM_DOM-1:0]  dom_on
);
  localparam int ENTRY_W = 2 * NUM_DOM;

  seq_state_t          st_q;
  logic [SLOT_W-1:0]   slot_q;
  logic                busy_q, done_q, err_q;
  logic [NUM_DOM-1:0]  on_q;
  logic [ENTRY_W-1:0]  entry;
  logic [NUM_DOM-1:0]  slot_up, slot_dn, pend;
  logic                slot_empty, slot_last, all_acked;
  logic                hs_load, hs_clear, trig, adv;
  logic                tmo_hit, settle_hit, settle_zero;

  // slot table: upper half power-up mask, lower half power-down mask
  pgs_slot_ram #(.DW(ENTRY_W), .DEPTH(NUM_SLOT)) slot_ram_i (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_slot),
    .wdata ({cfg_up, cfg_dn}),
    .raddr (slot_q),
    .rdata (entry)
  );

  assign slot_up    = entry[ENTRY_W-1:NUM_DOM];
  assign slot_dn    = entry[NUM_DOM-1:0];
  assign slot_empty = (slot_up == '0) && (slot_dn == '0);
  assign slot_last  = (slot_q == SLOT_W'(NUM_SLOT - 1));
  assign hs_load    = (st_q == ST_EVAL) && !slot_empty;
  assign all_acked  = ~|pend;
  assign hs_clear   = (st_q == ST_WAIT) && (all_acked || tmo_hit);
  assign trig       = (st_q == ST_IDLE) && (sw_start || hw_evt);
  assign settle_zero = (settle_cycles == '0);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    pgs_dom_hs dom_hs_i (
      .clk     (clk),
      .rst     (rst),
      .load    (hs_load),
      .clear   (hs_clear),
      .up_set  (slot_up[d]),
      .dn_set  (slot_dn[d]),
      .up_ack  (up_ack[d]),
      .dn_ack  (dn_ack[d]),
      .up_req  (up_req[d]),
      .dn_req  (dn_req[d]),
      .pending (pend[d])
    );
  end

  pgs_limit_cnt #(.W(TMO_W)) tmo_cnt_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (hs_load),
    .inc   (st_q == ST_WAIT),
    .limit (tmo_limit),
    .hit   (tmo_hit)
  );

  pgs_limit_cnt #(.W(SETTLE_W)) settle_cnt_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (st_q == ST_WAIT),
    .inc   (st_q == ST_SETTLE),
    .limit (settle_cycles - 1'b1),
    .hit   (settle_hit)
  );

  // conditions under which the current slot is finished
  always_comb begin
    adv = 1'b0;
    unique case (st_q)
      ST_EVAL:   adv = slot_empty;
      ST_WAIT:   adv = all_acked && settle_zero;
      ST_SETTLE: adv = settle_hit;
      default:   adv = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      on_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (trig) begin
            st_q   <= ST_FETCH;
            slot_q <= '0;
            busy_q <= 1'b1;
            err_q  <= 1'b0;
          end
        end
        ST_FETCH: st_q <= ST_EVAL;
        ST_EVAL: begin
          if (!slot_empty) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (all_acked) begin
            on_q <= (on_q | up_req) & ~dn_req;
            if (!settle_zero) st_q <= ST_SETTLE;
          end else if (tmo_hit) begin
            err_q  <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end
        end
        ST_SETTLE: ;
        default: st_q <= ST_IDLE;
      endcase
      if (adv) begin
        if (slot_last) begin
          st_q   <= ST_IDLE;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
          st_q   <= ST_FETCH;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign err    = err_q;
  assign dom_on = on_q;
endmodule

// File: rtl/pgs_seq_chk.sv
module pgs_seq_chk #(
  parameter int NUM_DOM = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               sw_start,
  input logic               hw_evt,
  input logic [NUM_DOM-1:0] up_req,
  input logic [NUM_DOM-1:0] dn_req,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic [NUM_DOM-1:0] dom_on
);
  logic any_req;
  assign any_req = (|up_req) || (|dn_req);

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && (sw_start || hw_evt)) |=> busy); // R2
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    any_req |-> busy); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (any_req && $past(any_req)) |-> ($stable(up_req) && $stable(dn_req))); // R4
  AST_UP_DN_EXCL: assert property (@(posedge clk) disable iff (rst)
    any_req |-> ((up_req & dn_req) == '0)); // R5
  AST_ON_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(dom_on)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !busy && !sw_start && !hw_evt) |=> err); // R10
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (!busy && !done && !any_req)); // R10
endmodule

bind pgate_slot_seq pgs_seq_chk #(.NUM_DOM(NUM_DOM)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .sw_start (sw_start),
  .hw_evt   (hw_evt),
  .up_req   (up_req),
  .dn_req   (dn_req),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .dom_on   (dom_on)
);

// File: tb/pgate_slot_seq_tb_top.sv
module pgate_slot_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int NS = 20;
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_slot = '0;
  logic [N-1:0]  cfg_up = '0, cfg_dn = '0;
  logic [7:0]    settle_cycles = '0;
  logic [11:0]   tmo_limit = 12'd30;
  logic          sw_start = 1'b0, hw_evt = 1'b0;
  logic [N-1:0]  up_req, dn_req;
  logic [N-1:0]  up_ack = '0, dn_ack = '0;
  logic          busy, done, err;
  logic [N-1:0]  dom_on;

  pgate_slot_seq dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_up(cfg_up), .cfg_dn(cfg_dn), .settle_cycles(settle_cycles),
    .tmo_limit(tmo_limit), .sw_start(sw_start), .hw_evt(hw_evt),
    .up_req(up_req), .dn_req(dn_req), .up_ack(up_ack), .dn_ack(dn_ack),
    .busy(busy), .done(done), .err(err), .dom_on(dom_on)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slot program shared by monitor and tasks
  logic [N-1:0] exp_up [NS];
  logic [N-1:0] exp_dn [NS];
  logic [N-1:0] stuck = '0;

  function automatic logic [N-1:0] mk_up(input int k, input int seed);
    if (((k + seed) % 5) == 3) return '0;
    return N'((k * 37 + seed * 29 + 11) & 255);
  endfunction

  function automatic logic [N-1:0] mk_dn(input int k, input int seed);
    if (((k + seed) % 5) == 3) return '0;
    return N'((k * 91 + seed * 53 + 7) & 255);
  endfunction

  // domain model: acknowledge after (d%3)+1 cycles of request
  int ucnt [N];
  int dcnt [N];
  always @(negedge clk) begin
    for (int d = 0; d < N; d++) begin
      if (up_req[d] && !stuck[d]) ucnt[d]++; else ucnt[d] = 0;
      if (dn_req[d] && !stuck[d]) dcnt[d]++; else dcnt[d] = 0;
      up_ack[d] = (ucnt[d] >= (d % 3) + 1);
      dn_ack[d] = (dcnt[d] >= (d % 3) + 1);
    end
  end

  // request monitor: order, masks, stability, idle gaps
  bit           mon_en = 0;
  int           mon_next, mon_last, mon_zero, mon_seen, mon_settle;
  bit           mon_prev;
  logic [N-1:0] mon_pu, mon_pd;
  always @(negedge clk) begin
    if (mon_en) begin
      if ((|up_req) || (|dn_req)) begin
        if (!mon_prev) begin
          while (mon_next < NS && exp_up[mon_next] == '0 && exp_dn[mon_next] == '0) mon_next++;
          if (mon_next < NS) begin
            chk("R4", "slot up mask", int'(up_req), int'(exp_up[mon_next]));
            chk("R5", "slot dn mask", int'(dn_req), int'(exp_dn[mon_next] & ~exp_up[mon_next]));
            if (mon_last >= 0)
              chk("R7", "idle gap", mon_zero, mon_settle + 2 + 2 * (mon_next - mon_last - 1));
          end else begin
            chk("R4", "request beyond last slot", 1, 0);
          end
          mon_last = mon_next;
          mon_next++;
          mon_seen++;
        end else if (up_req != mon_pu || dn_req != mon_pd) begin
          chk("R4", "request changed inside slot", int'({up_req, dn_req}), int'({mon_pu, mon_pd}));
        end
        mon_zero = 0;
        mon_prev = 1;
      end else begin
        mon_zero++;
        mon_prev = 0;
      end
      mon_pu = up_req;
      mon_pd = dn_req;
    end
  end

  task automatic program_slots(input int seed, input bit all_zero);
    for (int k = 0; k < NS; k++) begin
      exp_up[k] = all_zero ? '0 : mk_up(k, seed);
      exp_dn[k] = all_zero ? '0 : mk_dn(k, seed);
      cfg_we = 1'b1; cfg_slot = SW'(k); cfg_up = exp_up[k]; cfg_dn = exp_dn[k];
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  function automatic logic [N-1:0] fold_on(input logic [N-1:0] start);
    logic [N-1:0] on = start;
    for (int k = 0; k < NS; k++) on = (on | exp_up[k]) & ~(exp_dn[k] & ~exp_up[k]);
    return on;
  endfunction

  function automatic int count_full();
    int c = 0;
    for (int k = 0; k < NS; k++) if (exp_up[k] != '0 || exp_dn[k] != '0) c++;
    return c;
  endfunction

  task automatic run_seq(input bit use_hw, input int settle, input bit poke,
                         input logic [N-1:0] exp_on, output int busy_n);
    int dones = 0;
    int guard = 0;
    settle_cycles = 8'(settle);
    mon_settle = settle; mon_next = 0; mon_last = -1; mon_zero = 0;
    mon_seen = 0; mon_prev = 0; mon_pu = '0; mon_pd = '0;
    mon_en = 1;
    if (use_hw) hw_evt = 1'b1; else sw_start = 1'b1;
    @(negedge clk);
    hw_evt = 1'b0; sw_start = 1'b0;
    chk("R2", "busy after trigger", int'(busy), 1);
    chk("R11", "err cleared on start", int'(err), 0);
    busy_n = 1;
    while (busy && guard < 5000) begin
      sw_start = poke && (guard == 7);
      hw_evt   = poke && (guard == 9);
      @(negedge clk);
      guard++;
      if (busy) busy_n++;
      if (done) begin
        dones++;
        chk("R9", "busy low with done", int'(busy), 0);
      end
    end
    sw_start = 1'b0; hw_evt = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || done) chk("R3", "no restart after done", int'({busy, done}), 0);
    end
    chk("R9", "done pulses", dones, 1);
    chk("R8", "dom_on after sequence", int'(dom_on), int'(exp_on));
    chk("R4", "non-empty slots seen", mon_seen, count_full());
    mon_en = 0;
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] exp_on;
    int bn;
    int settles [4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "err", int'(err), 0);
    chk("R1", "requests", int'({up_req, dn_req}), 0);
    chk("R1", "dom_on", int'(dom_on), 0);

    // R6 all slots empty, with mid-sequence trigger pokes (R3)
    program_slots(0, 1'b1);
    exp_on = '0;
    run_seq(1'b0, 3, 1'b1, exp_on, bn);
    chk("R6", "busy cycles for empty table", bn, 2 * NS);

    // R4 R5 R7 R8 sweeps over slot programs and settle lengths
    for (int s = 1; s <= 4; s++) begin
      program_slots(s, 1'b0);
      exp_on = fold_on(exp_on);
      run_seq(s[0], settles[s-1], s == 2, exp_on, bn);
    end

    // R10 timeout: domain 0 never acknowledges
    program_slots(0, 1'b1);
    cfg_we = 1'b1; cfg_slot = '0; cfg_up = 8'h01; cfg_dn = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    stuck = 8'h01;
    tmo_limit = 12'd5;
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    begin
      int req_n = 0;
      int dn_cnt = 0;
      int g = 0;
      while (busy && g < 200) begin
        if (up_req != '0) req_n++;
        if (done) dn_cnt++;
        @(negedge clk);
        g++;
      end
      if (done) dn_cnt++;
      chk("R10", "request cycles before abort", req_n, 6);
      chk("R10", "err after timeout", int'(err), 1);
      chk("R10", "requests dropped", int'(up_req), 0);
      chk("R10", "no done on abort", dn_cnt, 0);
      chk("R10", "dom_on unchanged", int'(dom_on), int'(exp_on));
    end
    repeat (10) @(negedge clk);
    chk("R10", "err sticky while idle", int'(err), 1);

    // R11 recovery after error
    stuck = '0;
    tmo_limit = 12'd30;
    program_slots(7, 1'b0);
    exp_on = fold_on(exp_on);
    run_seq(1'b1, 1, 1'b0, exp_on, bn);
    chk("R11", "err stays clear after good run", int'(err), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule